// File: doc/BRIEF.md
# Aligned Double-Word Burst Mover

This block is one DMA channel that copies a run of 64-bit double words from a source region to a destination region. Data passes through an internal FIFO of eight double words. Reads fill the FIFO and writes drain it, through a single memory master port that carries one request at a time.

Each burst is cut so that it never crosses a boundary aligned to a programmable setting size. The cut is made independently on the read side and on the write side. When the source and destination offsets inside an aligned block differ, words therefore stay in the FIFO from one burst to the next.

Two mode bits change the cutting. A fixed-length mode drops the alignment term, so bursts use the full setting size. A single-read mode issues every FIFO fill as a string of one-beat reads, while writes still go out as bursts. Software loads the configuration inputs and pulses start. The done flag rises once every word has been written.

Top module: `aligned_burst_mover`

## Requirements
- R1: After a synchronous reset, `mem_rd_req`, `mem_wr_req` and `xfer_done` are low, and the FIFO holds no words.
- R2: A read burst starts at the next unread source address. Its `mem_len` is the smallest of three values: the double words left to the source's next aligned boundary, the double words not yet read, and the free FIFO entries (8 minus occupancy).
- R3: A write burst starts at the next unwritten destination address. Its `mem_len` is the smallest of three values: the double words left to the destination's next aligned boundary, the double words not yet written, and the FIFO occupancy. Words that do not fit stay in the FIFO for the next burst.
- R4: With `cfg_fixed_len` = 1, the boundary term in R2 and R3 is replaced by the full setting size, whatever the address offset.
- R5: `cfg_size_sel` = k selects a setting size of 2^k double words (0 gives 1, 3 gives 8). The aligned boundary is the next address whose byte address divided by 8 is a multiple of that size.
- R6: The first burst is a read.
  - After a read fill, a write follows if the FIFO holds data.
  - After a write, a read follows if unread words remain and the FIFO has a free entry.
  - If the preferred kind cannot run, the other kind runs instead.
- R7: With `cfg_src_single` = 1, the read fill chosen by R2 is issued as that many separate requests with `mem_len` = 1 at consecutive source addresses. Writes still follow R3.
- R8: The k-th double word presented on `mem_wdata` equals the k-th double word read from the source. The FIFO never holds more than 8 words.
- R9: `xfer_done` rises only after the last write beat is acknowledged, and it stays high with no request active until the next start. A start pulse, or a change to the configuration inputs, during a transfer has no effect on that transfer.
- R10: `mem_addr` is a byte address. `mem_len` is the beat count, from 1 to 8. A request stays high with stable address and length until it has received `mem_len` acknowledges, and it drops in the cycle after the last acknowledge.
- R11: `mem_rd_req` and `mem_wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start pulse, sampled only while idle or done |
| cfg_src_addr | input | ADDR_W | Source byte address, double-word aligned |
| cfg_dst_addr | input | ADDR_W | Destination byte address, double-word aligned |
| cfg_byte_count | input | CNT_W | Transfer length in bytes, a multiple of 8 |
| cfg_size_sel | input | SZ_W | Setting size is 2^value double words |
| cfg_fixed_len | input | 1 | 1: bursts ignore address alignment |
| cfg_src_single | input | 1 | 1: FIFO fills issued as one-beat reads |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_len | output | LEN_W | Burst length in beats |
| mem_wdata | output | DATA_W | Write data for the current beat |
| mem_rdata | input | DATA_W | Read data, valid with acknowledge |
| mem_ack | input | 1 | Per-beat acknowledge |
| xfer_done | output | 1 | Transfer complete, held until next start |

## Verification
A wrong word count, a wrong boundary offset or a wrong occupancy first shows up in the `mem_len` or `mem_addr` of the very next request. The bench compares both against a burst schedule computed from the requirements at the moment each request rises, so such a fault is caught within one burst. A FIFO pointer fault shows up instead as a wrong `mem_wdata` on the first beat that follows it. A premature or missing end is seen as `xfer_done` rising while scheduled bursts are still pending, or the transfer never finishing.

// File: rtl/abm_pkg.sv
package abm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PICK,
    PH_READ,
    PH_RGAP,
    PH_WRITE,
    PH_DONE
  } phase_t;

endpackage

// File: rtl/abm_burst_calc.sv
module abm_burst_calc #(
  parameter int MAX_SZ_LOG = 3,
  parameter int WCNT_W     = 13,
  parameter int LEN_W      = 4,
  parameter int SZ_W       = 2
) (
  input  logic [MAX_SZ_LOG-1:0] dw_off,
  input  logic [SZ_W-1:0]       size_sel,
  input  logic                  fixed,
  input  logic [WCNT_W-1:0]     remain,
  input  logic [LEN_W-1:0]      avail,
  output logic [LEN_W-1:0]      len
);

  logic [LEN_W-1:0] size_w;
  logic [LEN_W-1:0] off_w;
  logic [LEN_W-1:0] bound_w;
  logic [LEN_W-1:0] rem_w;

  always_comb begin
    size_w  = LEN_W'(1) << size_sel;
    off_w   = LEN_W'(dw_off) & (size_w - LEN_W'(1));
    bound_w = fixed ? size_w : (size_w - off_w);
    rem_w   = (remain > WCNT_W'(bound_w)) ? bound_w : LEN_W'(remain);
    len     = (rem_w < avail) ? rem_w : avail;
  end

endmodule

// File: rtl/abm_dw_fifo.sv
module abm_dw_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int OCC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] next_head,
  output logic [OCC_W-1:0]  occ
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic [PTR_W-1:0]  rp_q;
  logic [OCC_W-1:0]  occ_q;

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + PTR_W'(1);
      if (pop)  rp_q <= rp_q + PTR_W'(1);
      case ({push, pop})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign head      = store[rp_q];
  assign next_head = store[rp_q + PTR_W'(1)];
  assign occ       = occ_q;

endmodule

// File: rtl/abm_sequencer.sv
module abm_sequencer import abm_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int CNT_W      = 16,
  parameter int DEPTH      = 8,
  parameter int MAX_SZ_LOG = 3,
  parameter int LEN_W      = 4,
  parameter int SZ_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [SZ_W-1:0]   size_sel,
  input  logic              fixed_len,
  input  logic              src_single,
  input  logic [LEN_W-1:0]  occ,
  input  logic [DATA_W-1:0] head,
  input  logic [DATA_W-1:0] next_head,
  input  logic              mem_ack,
  output logic              push,
  output logic              pop,
  output logic              rd_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic              single_mode
);

  localparam int WCNT_W = CNT_W - 3;

  phase_t            phase_q;
  logic [ADDR_W-1:0] src_q, dst_q, addr_q;
  logic [WCNT_W-1:0] rd_left_q, wr_left_q;
  logic [SZ_W-1:0]   size_q;
  logic              fixed_q, single_q, last_rd_q;
  logic [LEN_W-1:0]  chunk_q, len_q;
  logic              rd_req_q, wr_req_q, done_q;
  logic [DATA_W-1:0] wdata_q;

  logic [LEN_W-1:0]  free_w, rd_len, wr_len;
  logic              can_rd, can_wr, pick_rd;
  logic [WCNT_W-1:0] word_cnt;

  assign free_w   = LEN_W'(DEPTH) - occ;
  assign word_cnt = WCNT_W'(byte_count >> 3);

  abm_burst_calc #(
    .MAX_SZ_LOG(MAX_SZ_LOG), .WCNT_W(WCNT_W), .LEN_W(LEN_W), .SZ_W(SZ_W)
  ) u_rd_calc (
    .dw_off  (src_q[3 +: MAX_SZ_LOG]),
    .size_sel(size_q),
    .fixed   (fixed_q),
    .remain  (rd_left_q),
    .avail   (free_w),
    .len     (rd_len)
  );

  abm_burst_calc #(
    .MAX_SZ_LOG(MAX_SZ_LOG), .WCNT_W(WCNT_W), .LEN_W(LEN_W), .SZ_W(SZ_W)
  ) u_wr_calc (
    .dw_off  (dst_q[3 +: MAX_SZ_LOG]),
    .size_sel(size_q),
    .fixed   (fixed_q),
    .remain  (wr_left_q),
    .avail   (occ),
    .len     (wr_len)
  );

  assign can_rd  = (rd_left_q != '0) && (free_w != '0);
  assign can_wr  = (occ != '0);
  assign pick_rd = can_rd && (!last_rd_q || !can_wr);

  assign push = (phase_q == PH_READ)  && mem_ack;
  assign pop  = (phase_q == PH_WRITE) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      addr_q    <= '0;
      rd_left_q <= '0;
      wr_left_q <= '0;
      size_q    <= '0;
      fixed_q   <= 1'b0;
      single_q  <= 1'b0;
      last_rd_q <= 1'b0;
      chunk_q   <= '0;
      len_q     <= '0;
      rd_req_q  <= 1'b0;
      wr_req_q  <= 1'b0;
      done_q    <= 1'b0;
      wdata_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE, PH_DONE: begin
          if (start) begin
            src_q     <= src_addr;
            dst_q     <= dst_addr;
            rd_left_q <= word_cnt;
            wr_left_q <= word_cnt;
            size_q    <= size_sel;
            fixed_q   <= fixed_len;
            single_q  <= src_single;
            last_rd_q <= 1'b0;
            done_q    <= 1'b0;
            phase_q   <= PH_PICK;
          end
        end
        PH_PICK: begin
          if (pick_rd) begin
            rd_req_q <= 1'b1;
            addr_q   <= src_q;
            len_q    <= single_q ? LEN_W'(1) : rd_len;
            chunk_q  <= rd_len;
            phase_q  <= PH_READ;
          end else if (can_wr) begin
            wr_req_q <= 1'b1;
            addr_q   <= dst_q;
            len_q    <= wr_len;
            chunk_q  <= wr_len;
            wdata_q  <= head;
            phase_q  <= PH_WRITE;
          end else begin
            done_q  <= 1'b1;
            phase_q <= PH_DONE;
          end
        end
        PH_READ: begin
          if (mem_ack) begin
            src_q     <= src_q + ADDR_W'(8);
            rd_left_q <= rd_left_q - WCNT_W'(1);
            chunk_q   <= chunk_q - LEN_W'(1);
            if (chunk_q == LEN_W'(1)) begin
              rd_req_q  <= 1'b0;
              last_rd_q <= 1'b1;
              phase_q   <= PH_PICK;
            end else if (single_q) begin
              rd_req_q <= 1'b0;
              phase_q  <= PH_RGAP;
            end
          end
        end
        PH_RGAP: begin
          rd_req_q <= 1'b1;
          addr_q   <= src_q;
          len_q    <= LEN_W'(1);
          phase_q  <= PH_READ;
        end
        PH_WRITE: begin
          if (mem_ack) begin
            dst_q     <= dst_q + ADDR_W'(8);
            wr_left_q <= wr_left_q - WCNT_W'(1);
            chunk_q   <= chunk_q - LEN_W'(1);
            wdata_q   <= next_head;
            if (chunk_q == LEN_W'(1)) begin
              wr_req_q  <= 1'b0;
              last_rd_q <= 1'b0;
              phase_q   <= PH_PICK;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign rd_req      = rd_req_q;
  assign wr_req      = wr_req_q;
  assign addr        = addr_q;
  assign len         = len_q;
  assign wdata       = wdata_q;
  assign done        = done_q;
  assign single_mode = single_q;

endmodule

// File: rtl/aligned_burst_mover.sv
module aligned_burst_mover #(
  parameter  int ADDR_W     = 32,
  parameter  int DATA_W     = 64,
  parameter  int CNT_W      = 16,
  parameter  int DEPTH      = 8,
  parameter  int MAX_SZ_LOG = 3,
  localparam int LEN_W      = $clog2(DEPTH + 1),
  localparam int SZ_W       = $clog2(MAX_SZ_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [CNT_W-1:0]  cfg_byte_count,
  input  logic [SZ_W-1:0]   cfg_size_sel,
  input  logic              cfg_fixed_len,
  input  logic              cfg_src_single,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              xfer_done
);

  logic              fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_head, fifo_next;
  logic [LEN_W-1:0]  fifo_occ;
  logic              mode_single;

  abm_dw_fifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .OCC_W(LEN_W)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (fifo_push),
    .din      (mem_rdata),
    .pop      (fifo_pop),
    .head     (fifo_head),
    .next_head(fifo_next),
    .occ      (fifo_occ)
  );

  abm_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH),
    .MAX_SZ_LOG(MAX_SZ_LOG), .LEN_W(LEN_W), .SZ_W(SZ_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (cfg_start),
    .src_addr   (cfg_src_addr),
    .dst_addr   (cfg_dst_addr),
    .byte_count (cfg_byte_count),
    .size_sel   (cfg_size_sel),
    .fixed_len  (cfg_fixed_len),
    .src_single (cfg_src_single),
    .occ        (fifo_occ),
    .head       (fifo_head),
    .next_head  (fifo_next),
    .mem_ack    (mem_ack),
    .push       (fifo_push),
    .pop        (fifo_pop),
    .rd_req     (mem_rd_req),
    .wr_req     (mem_wr_req),
    .addr       (mem_addr),
    .len        (mem_len),
    .wdata      (mem_wdata),
    .done       (xfer_done),
    .single_mode(mode_single)
  );

endmodule

// File: rtl/abm_checker.sv
module abm_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_start,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic              mem_ack,
  input logic              xfer_done,
  input logic [LEN_W-1:0]  occ,
  input logic              single_mode
);

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req)); // R11

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> (mem_len != '0 && mem_len <= LEN_W'(DEPTH))); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr) && $stable(mem_len))); // R10

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_len))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= LEN_W'(DEPTH)); // R8

  AST_SINGLE_RD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && single_mode) |-> (mem_len == LEN_W'(1))); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (!mem_rd_req && !mem_wr_req)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !cfg_start) |=> xfer_done); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd_req || mem_wr_req) && cfg_start) |=> !xfer_done); // R9

endmodule

bind aligned_burst_mover abm_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LEN_W(LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_start  (cfg_start),
  .mem_rd_req (mem_rd_req),
  .mem_wr_req (mem_wr_req),
  .mem_addr   (mem_addr),
  .mem_len    (mem_len),
  .mem_ack    (mem_ack),
  .xfer_done  (xfer_done),
  .occ        (fifo_occ),
  .single_mode(mode_single)
);

// File: tb/aligned_burst_mover_tb.sv
module aligned_burst_mover_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_start = 1'b0;
  logic [31:0] cfg_src_addr = '0;
  logic [31:0] cfg_dst_addr = '0;
  logic [15:0] cfg_byte_count = '0;
  logic [1:0]  cfg_size_sel = '0;
  logic        cfg_fixed_len = 1'b0;
  logic        cfg_src_single = 1'b0;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_addr;
  logic [3:0]  mem_len;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        xfer_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  aligned_burst_mover u_dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_byte_count(cfg_byte_count), .cfg_size_sel(cfg_size_sel),
    .cfg_fixed_len(cfg_fixed_len), .cfg_src_single(cfg_src_single),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .xfer_done(xfer_done)
  );

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    int          len;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] dat_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  string       cur_tag = "R1";
  bit          stall = 1'b0;
  bit          tick = 1'b0;
  int          beat = 0;
  int          cur_len = 0;
  bit          prev_req = 1'b0;

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic int bound_of(input logic [31:0] a, input int sz, input bit fixed);
    return fixed ? sz : sz - (int'(a >> 3) & (sz - 1));
  endfunction

  function automatic int min3(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  // Driver side of the scoreboard: expected bursts and data, built from R2-R7.
  task automatic plan(input logic [31:0] src, input logic [31:0] dst, input int words,
                      input int sel, input bit fixed, input bit single);
    int          rdl = words;
    int          wrl = words;
    int          occ = 0;
    int          sz = 1 << sel;
    logic [31:0] s = src;
    logic [31:0] d = dst;
    bit          last_rd = 1'b0;
    for (int k = 0; k < words; k++) dat_q.push_back(pat(src + 32'(8 * k)));
    while (wrl > 0) begin
      int free = DEPTH - occ;
      bit canr = (rdl > 0) && (free > 0);
      bit canw = (occ > 0);
      int ln;
      if (canr && (!last_rd || !canw)) begin
        ln = min3(bound_of(s, sz, fixed), rdl, free);
        if (single) begin
          for (int i = 0; i < ln; i++) exp_q.push_back('{1'b0, s + 32'(8 * i), 1});
        end else begin
          exp_q.push_back('{1'b0, s, ln});
        end
        s = s + 32'(8 * ln);
        rdl -= ln;
        occ += ln;
        last_rd = 1'b1;
      end else begin
        ln = min3(bound_of(d, sz, fixed), wrl, occ);
        exp_q.push_back('{1'b1, d, ln});
        d = d + 32'(8 * ln);
        wrl -= ln;
        occ -= ln;
        last_rd = 1'b0;
      end
    end
  endtask

  // Memory model: per-beat counter.
  always @(posedge clk) begin
    if (rst || !(mem_rd_req || mem_wr_req)) beat <= 0;
    else if (mem_ack) beat <= beat + 1;
  end

  // Monitor and acknowledge generation, away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    bit   req;
    tick = ~tick;
    if (rst) begin
      mem_ack  = 1'b0;
      prev_req = 1'b0;
    end else begin
      req = mem_rd_req || mem_wr_req;
      if (req && !prev_req) begin
        chk(!(mem_rd_req && mem_wr_req), "R11", "both requests high",
            {62'd0, mem_rd_req, mem_wr_req}, 64'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected burst at", 64'(mem_addr), 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk(e.wr == mem_wr_req, "R6", "burst kind (1=write)",
              64'(mem_wr_req), 64'(e.wr));
          chk(e.addr == mem_addr, cur_tag, "burst address", 64'(mem_addr), 64'(e.addr));
          chk(e.len == int'(mem_len), cur_tag, "burst length",
              64'(mem_len), 64'(e.len));
        end
        cur_len = int'(mem_len);
      end
      if (!req && prev_req)
        chk(beat == cur_len, "R10", "beats before request drop", 64'(beat), 64'(cur_len));
      mem_ack   = req && (beat < int'(mem_len)) && (!stall || tick);
      mem_rdata = pat(mem_addr + 32'(8 * beat));
      if (mem_wr_req && mem_ack) begin
        if (dat_q.size() == 0) chk(1'b0, "R8", "extra write beat", mem_wdata, 64'd0);
        else begin
          logic [63:0] want;
          want = dat_q.pop_front();
          chk(mem_wdata == want, "R8", "write data", mem_wdata, want);
        end
      end
      prev_req = req;
    end
  end

  task automatic run_xfer(input string tag, input logic [31:0] src, input logic [31:0] dst,
                          input int words, input int sel, input bit fixed,
                          input bit single, input bit stl, input bit poke);
    int guard = 0;
    cur_tag = tag;
    stall   = stl;
    plan(src, dst, words, sel, fixed, single);
    @(negedge clk);
    cfg_src_addr   = src;
    cfg_dst_addr   = dst;
    cfg_byte_count = 16'(words * 8);
    cfg_size_sel   = 2'(sel);
    cfg_fixed_len  = fixed;
    cfg_src_single = single;
    cfg_start      = 1'b1;
    @(negedge clk);
    cfg_start    = 1'b0;
    cfg_src_addr = 32'hDEAD_0000;  // changed after start: must not matter (R9)
    if (poke) begin
      repeat (12) @(negedge clk);
      chk(xfer_done == 1'b0, "R9", "busy when second start applied", 64'(xfer_done), 64'd0);
      cfg_src_addr   = 32'h0000_4000;
      cfg_byte_count = 16'd64;
      cfg_fixed_len  = 1'b1;
      cfg_start      = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
    end
    while (!xfer_done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(xfer_done, tag, "transfer completed", 64'(xfer_done), 64'd1);
    chk(exp_q.size() == 0, "R9", "bursts still pending at done", 64'(exp_q.size()), 64'd0);
    chk(dat_q.size() == 0, "R8", "words not written at done", 64'(dat_q.size()), 64'd0);
    repeat (4) @(negedge clk);
    chk(xfer_done && !mem_rd_req && !mem_wr_req, "R9", "done held and bus quiet",
        {61'd0, xfer_done, mem_rd_req, mem_wr_req}, 64'd4);
    exp_q.delete();
    dat_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_rd_req && !mem_wr_req && !xfer_done, "R1", "outputs after reset",
        {61'd0, mem_rd_req, mem_wr_req, xfer_done}, 64'd0);

    // R2: equal offsets, first read up to 0xC0
    run_xfer("R2", 32'h0000_10A8, 32'h0000_2028, 16, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: unequal offsets, words remain in the FIFO
    run_xfer("R3", 32'h0000_10A8, 32'h0000_2030, 16, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    // R4: fixed length ignores alignment
    run_xfer("R4", 32'h0000_10A8, 32'h0000_2030, 20, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: single-beat reads, writes still burst
    run_xfer("R7", 32'h0000_10A8, 32'h0000_2030, 12, 3, 1'b0, 1'b1, 1'b1, 1'b0);
    // R5: setting size of 2 and of 1 double words
    run_xfer("R5", 32'h0000_1008, 32'h0000_2010, 10, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_xfer("R5", 32'h0000_3000, 32'h0000_5008, 3, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R6: size 4 with odd offsets on both sides
    run_xfer("R6", 32'h0000_6018, 32'h0000_7008, 13, 2, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: start during a long transfer is ignored
    run_xfer("R9", 32'h0000_8038, 32'h0000_9010, 40, 3, 1'b0, 1'b0, 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule